// File: doc/BRIEF.md
# Octave-Switched Sine Table Generator

This block turns a requested frequency between 20 Hz and 20 kHz into a stream of 12-bit offset-binary sample codes for a DAC. It walks an address through one stored sine cycle of 4096 points. The walk advances at a rate derived from the system clock and the requested frequency. Each step produces one sample, and a one-cycle strobe marks that sample.

To keep the sample rate bounded, the block keeps fewer points per cycle as the frequency rises. Each time the request passes another octave boundary (625, 1250, 2500, 5000 and 10000 Hz), it keeps half as many points. It does this by striding through the same stored table with a step of 2^k. So from 625 Hz upward, frequency times points-per-cycle never exceeds 2.56 million samples per second.

A second waveform choice gives a sine clipped flat at about 78 % of full amplitude, for a peak-to-RMS ratio of about 1.246. Changes to frequency, range or waveform take effect only when the address returns to zero, so a cycle is never broken part-way through. The DAC, the reconstruction filter and the analog stages are outside this block.

Top module: `octave_sine_gen`

## Requirements
- R1: After reset, `dac_code` is 2048, `sample_stb` is low and `table_len` is 4096.
- R2: `table_len` is 4096 >> k, where k counts how many of the limits 625, 1250, 2500, 5000 and 10000 Hz the captured frequency strictly exceeds. For example, 625 Hz gives 4096, 626 Hz gives 2048, 10000 Hz gives 256 and 10001 Hz gives 128. The frequency and waveform are captured on the first cycle that `enable` is high.
- R3: The strobe rate averages freq × table_len / CLK_HZ per clock. A remainder accumulator carries fractions forward, so over any window the strobe count is within one of that product. Two strobes are never on adjacent clocks.
- R4: Sample n of a cycle uses table address a = n·(4096/table_len), and the first sample after enable uses address 0. The magnitude is m = round(2047·sin((i+0.5)·π/2048)). Here i = a mod 1024, except that i = 1023 − (a mod 1024) when bit 10 of a is set. The code is 2048 + m when bit 11 of a is clear, and 2048 − m when bit 11 is set.
- R5: Over a full 4096-point cycle, s(a) + s(a+2048) = 4096 and s(a) = s(2047−a). Every emitted code lies between 1 and 4095.
- R6: With `wave_sel` = 1, the magnitude m is limited to 1597, so the highest code is 3645.
- R7: A change of frequency or waveform made during a cycle takes effect only when the address wraps to zero. The current cycle finishes with its old stride.
- R8: While `enable` is low, `dac_code` is held at 2048 and no strobe occurs. Raising `enable` again restarts at address 0.
- R9: At 20000 Hz the strobe rate is 2.56 MHz, which is the ceiling: 320 strobes per 6250 clocks at 50 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the generator; low holds mid-scale |
| freq_hz | input | 15 | Requested output frequency in Hz |
| wave_sel | input | 1 | 0 = pure sine, 1 = clipped sine |
| dac_code | output | 12 | Offset-binary sample code |
| sample_stb | output | 1 | One-cycle pulse marking a new sample |
| table_len | output | 13 | Points per output cycle currently in use |

## Verification
The bench sets requests exactly at each octave limit and one hertz above it. A design with the comparison off by one would report the wrong `table_len` at 625, 626, 10000 or 10001 Hz. The bench captures a whole 4096-point cycle and checks it against the formula and both symmetries; a wrong quadrant fold or sign would break the mirror sums around 2048. The bench changes frequency ten samples into a cycle and requires the old stride to continue until the wrap. A design that applied the change at once would show a sample sequence that jumps part-way through. Strobe counts over fixed windows at a non-integer clock ratio expose an accumulator that drops its remainder, and a restart after disabling exposes stale phase.

// File: rtl/osg_pkg.sv
package osg_pkg;

  typedef enum logic {
    WAVE_SINE = 1'b0,
    WAVE_CLIP = 1'b1
  } wave_e;

  localparam real OSG_PI = 3.141592653589793;

endpackage

// File: rtl/osg_range_sel.sv
module osg_range_sel #(
  parameter int FREQ_W  = 15,
  parameter int BASE_HZ = 625,
  parameter int N_OCT   = 5,
  parameter int K_W     = 3
) (
  input  logic [FREQ_W-1:0] freq,
  output logic [K_W-1:0]    oct_k
);

  logic [N_OCT-1:0] above;

  genvar g;
  generate
    for (g = 0; g < N_OCT; g++) begin : g_lim
      localparam int LIMIT = BASE_HZ << g;
      assign above[g] = (freq > FREQ_W'(LIMIT));
    end
  endgenerate

  assign oct_k = K_W'($countones(above));

endmodule

// File: rtl/osg_rate_acc.sv
module osg_rate_acc #(
  parameter int CLK_HZ = 50_000_000,
  parameter int INC_W  = 27,
  parameter int ACC_W  = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [INC_W-1:0] inc,
  output logic             tick
);

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;
  logic             over;

  assign sum  = {1'b0, acc} + (ACC_W+1)'(inc);
  assign over = (sum >= (ACC_W+1)'(CLK_HZ));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= over;
      if (over) acc <= ACC_W'(sum - (ACC_W+1)'(CLK_HZ));
      else      acc <= ACC_W'(sum);
    end
  end

endmodule

// File: rtl/osg_phase_ctl.sv
module osg_phase_ctl #(
  parameter int ADDR_W = 12,
  parameter int FREQ_W = 15,
  parameter int K_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [FREQ_W-1:0] freq_req,
  input  logic [K_W-1:0]    k_req,
  input  logic              wave_req,
  input  logic              tick,
  output logic [FREQ_W-1:0] f_act,
  output logic [K_W-1:0]    k_act,
  output logic              running,
  output logic              rd_v,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_wave
);

  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] addr_n;
  logic              wave_act;

  assign step   = ADDR_W'(1) << k_act;
  assign addr_n = addr + step;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_act    <= '0;
      k_act    <= '0;
      wave_act <= 1'b0;
      running  <= 1'b0;
      addr     <= '0;
      rd_v     <= 1'b0;
      rd_addr  <= '0;
      rd_wave  <= 1'b0;
    end else if (!enable) begin
      running <= 1'b0;
      addr    <= '0;
      rd_v    <= 1'b0;
    end else if (!running) begin
      f_act    <= freq_req;
      k_act    <= k_req;
      wave_act <= wave_req;
      running  <= 1'b1;
      addr     <= '0;
      rd_v     <= 1'b0;
    end else begin
      rd_v <= tick;
      if (tick) begin
        rd_addr <= addr;
        rd_wave <= wave_act;
        addr    <= addr_n;
        if (addr_n == '0) begin
          f_act    <= freq_req;
          k_act    <= k_req;
          wave_act <= wave_req;
        end
      end
    end
  end

endmodule

// File: rtl/osg_wave_rom.sv
module osg_wave_rom
  import osg_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 12,
  parameter int CLIP_MAG = 1597
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              rd_v,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_wave,
  output logic              out_v,
  output logic [DATA_W-1:0] out_code
);

  localparam int QA_W   = ADDR_W - 2;
  localparam int QDEPTH = 1 << QA_W;
  localparam int MAG_W  = DATA_W - 1;
  localparam int AMP    = (1 << MAG_W) - 1;
  localparam int MID    = 1 << MAG_W;

  logic [MAG_W-1:0] rom [QDEPTH];

  initial begin
    for (int i = 0; i < QDEPTH; i++) begin
      rom[i] = MAG_W'($rtoi(real'(AMP) *
               $sin((real'(i) + 0.5) * OSG_PI / (2.0 * real'(QDEPTH))) + 0.5));
    end
  end

  logic [QA_W-1:0]  idx;
  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic             clip_q;
  logic             v_q;
  logic [MAG_W-1:0] mag_lim;

  assign idx = rd_addr[ADDR_W-2] ? ~rd_addr[QA_W-1:0] : rd_addr[QA_W-1:0];

  always_ff @(posedge clk) begin
    mag_q <= rom[idx];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      v_q    <= 1'b0;
      neg_q  <= 1'b0;
      clip_q <= 1'b0;
    end else begin
      v_q    <= rd_v;
      neg_q  <= rd_addr[ADDR_W-1];
      clip_q <= (wave_e'(rd_wave) == WAVE_CLIP);
    end
  end

  assign mag_lim = (clip_q && (mag_q > MAG_W'(CLIP_MAG))) ? MAG_W'(CLIP_MAG) : mag_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_v    <= 1'b0;
      out_code <= DATA_W'(MID);
    end else begin
      out_v <= v_q;
      if (v_q) begin
        out_code <= neg_q ? DATA_W'(MID) - DATA_W'(mag_lim)
                          : DATA_W'(MID) + DATA_W'(mag_lim);
      end
    end
  end

endmodule

// File: rtl/octave_sine_gen.sv
module octave_sine_gen #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int FREQ_W   = 15,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 12,
  parameter int BASE_HZ  = 625,
  parameter int N_OCT    = 5,
  parameter int CLIP_MAG = 1597
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [FREQ_W-1:0] freq_hz,
  input  logic              wave_sel,
  output logic [DATA_W-1:0] dac_code,
  output logic              sample_stb,
  output logic [ADDR_W:0]   table_len
);

  localparam int K_W   = $clog2(N_OCT + 1);
  localparam int INC_W = FREQ_W + ADDR_W;
  localparam int ACC_A = INC_W + 1;
  localparam int ACC_B = $clog2(CLK_HZ) + 1;
  localparam int ACC_W = (ACC_A > ACC_B) ? ACC_A : ACC_B;

  logic [K_W-1:0]    k_req;
  logic [K_W-1:0]    k_act;
  logic [FREQ_W-1:0] f_act;
  logic              running;
  logic              tick;
  logic [INC_W-1:0]  inc;
  logic              rd_v;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_wave;

  osg_range_sel #(
    .FREQ_W (FREQ_W),
    .BASE_HZ(BASE_HZ),
    .N_OCT  (N_OCT),
    .K_W    (K_W)
  ) u_range (
    .freq (freq_hz),
    .oct_k(k_req)
  );

  assign inc = INC_W'(f_act) << (ADDR_W - int'(k_act));

  osg_rate_acc #(
    .CLK_HZ(CLK_HZ),
    .INC_W (INC_W),
    .ACC_W (ACC_W)
  ) u_rate (
    .clk  (clk),
    .rst  (rst),
    .clear(!running),
    .inc  (inc),
    .tick (tick)
  );

  osg_phase_ctl #(
    .ADDR_W(ADDR_W),
    .FREQ_W(FREQ_W),
    .K_W   (K_W)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .freq_req(freq_hz),
    .k_req   (k_req),
    .wave_req(wave_sel),
    .tick    (tick),
    .f_act   (f_act),
    .k_act   (k_act),
    .running (running),
    .rd_v    (rd_v),
    .rd_addr (rd_addr),
    .rd_wave (rd_wave)
  );

  osg_wave_rom #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CLIP_MAG(CLIP_MAG)
  ) u_rom (
    .clk     (clk),
    .rst     (rst),
    .flush   (!enable),
    .rd_v    (rd_v),
    .rd_addr (rd_addr),
    .rd_wave (rd_wave),
    .out_v   (sample_stb),
    .out_code(dac_code)
  );

  always_ff @(posedge clk) begin
    if (rst) table_len <= (ADDR_W+1)'(1) << ADDR_W;
    else     table_len <= (ADDR_W+1)'(1) << (ADDR_W - int'(k_act));
  end

endmodule

// File: rtl/osg_chk.sv
module osg_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12,
  parameter int N_OCT  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [DATA_W-1:0] dac_code,
  input logic              sample_stb,
  input logic [ADDR_W:0]   table_len
);

  localparam int MID     = 1 << (DATA_W - 1);
  localparam int MIN_LEN = (1 << ADDR_W) >> N_OCT;

  // R1
  post_reset_mid_chk: assert property (@(posedge clk)
    rst |=> (dac_code == DATA_W'(MID) && !sample_stb));

  // R8
  idle_mid_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (dac_code == DATA_W'(MID) && !sample_stb));

  // R3
  stb_gap_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  // R2
  len_pow2_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(table_len) == 1 && table_len >= (ADDR_W+1)'(MIN_LEN)));

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (dac_code != '0));

endmodule

bind octave_sine_gen osg_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .N_OCT (N_OCT)
) u_osg_chk (
  .clk       (clk),
  .rst       (rst),
  .enable    (enable),
  .dac_code  (dac_code),
  .sample_stb(sample_stb),
  .table_len (table_len)
);

// File: tb/octave_sine_gen_bench.sv
module octave_sine_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [14:0] freq_hz = '0;
  logic        wave_sel = 1'b0;
  logic [11:0] dac_code;
  logic        sample_stb;
  logic [12:0] table_len;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int smp [0:4095];
  int lens[0:4095];

  always #10 clk = ~clk;

  octave_sine_gen u_octave_sine_gen (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .freq_hz   (freq_hz),
    .wave_sel  (wave_sel),
    .dac_code  (dac_code),
    .sample_stb(sample_stb),
    .table_len (table_len)
  );

  function automatic int model(int a, bit clp);
    int  j   = a % 1024;
    int  i   = (((a >> 10) & 1) == 1) ? 1023 - j : j;
    real v   = 2047.0 * $sin((real'(i) + 0.5) * 3.141592653589793 / 2048.0);
    int  m   = $rtoi(v + 0.5);
    if (clp && m > 1597) m = 1597;
    return (((a >> 11) & 1) == 1) ? 2048 - m : 2048 + m;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(int f, bit w);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    freq_hz  = 15'(f);
    wave_sel = w;
    enable   = 1'b1;
  endtask

  task automatic collect(int first, int n);
    for (int k = first; k < first + n; k++) begin
      int waited = 0;
      do begin
        @(negedge clk);
        waited++;
      end while (!sample_stb && waited < 3000);
      smp[k]  = int'(dac_code);
      lens[k] = int'(table_len);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dac_code == 12'd2048, "R1 reset code", int'(dac_code), 2048);
    chk(!sample_stb, "R1 reset strobe", int'(sample_stb), 0);
    chk(table_len == 13'd4096, "R1 reset length", int'(table_len), 4096);
  endtask

  task automatic t_ranges;
    int fs[12] = '{20, 625, 626, 1250, 1251, 2500, 2501, 5000, 5001, 10000, 10001, 20000};
    int ls[12] = '{4096, 4096, 2048, 2048, 1024, 1024, 512, 512, 256, 256, 128, 128};
    for (int n = 0; n < 12; n++) begin
      restart(fs[n], 1'b0);
      repeat (4) @(negedge clk);
      chk(int'(table_len) == ls[n], $sformatf("R2 length at %0d Hz", fs[n]),
          int'(table_len), ls[n]);
    end
  endtask

  task automatic count_window(int f, int win, int lo, int hi, string req);
    int cnt = 0;
    restart(f, 1'b0);
    collect(0, 1);
    for (int c = 0; c < win; c++) begin
      @(negedge clk);
      if (sample_stb) cnt++;
    end
    chk(cnt >= lo && cnt <= hi, req, cnt, lo);
  endtask

  task automatic t_rate;
    count_window(20000, 6250, 319, 321, "R9 ceiling rate at 20000 Hz");
    count_window(7000, 6250, 223, 225, "R3 rate at 7000 Hz");
    count_window(20, 30000, 48, 50, "R3 rate at 20 Hz");
  endtask

  task automatic t_full_table;
    int bad_f = 0, bad_s = 0, bad_m = 0, lo = 4096, hi = 0;
    restart(625, 1'b0);
    collect(0, 4096);
    for (int a = 0; a < 4096; a++) begin
      if (smp[a] != model(a, 1'b0)) begin
        if (bad_f == 0) chk(1'b0, $sformatf("R4 sample %0d", a), smp[a], model(a, 1'b0));
        bad_f++;
      end
      if (smp[a] < lo) lo = smp[a];
      if (smp[a] > hi) hi = smp[a];
    end
    chk(bad_f == 0, "R4 full 4096-point cycle", bad_f, 0);
    for (int a = 0; a < 2048; a++) begin
      if (smp[a] + smp[a + 2048] != 4096) bad_s++;
      if (smp[a] != smp[2047 - a]) bad_m++;
    end
    chk(bad_s == 0, "R5 half-cycle sum about mid-scale", bad_s, 0);
    chk(bad_m == 0, "R5 mirror within half-cycle", bad_m, 0);
    chk(lo >= 1 && hi <= 4095, "R5 code range", lo, 1);
    chk(lens[100] == 4096, "R2 length at 625 Hz while running", lens[100], 4096);
  endtask

  task automatic t_short_cycle;
    int bad = 0;
    restart(20000, 1'b0);
    collect(0, 129);
    for (int n = 0; n < 128; n++) if (smp[n] != model(32 * n, 1'b0)) bad++;
    chk(bad == 0, "R4 128-point cycle uses stride 32", bad, 0);
    chk(smp[128] == model(0, 1'b0), "R4 wrap back to address 0", smp[128], model(0, 1'b0));
  endtask

  task automatic t_clip;
    int bad = 0, hi = 0;
    restart(20000, 1'b1);
    collect(0, 128);
    for (int n = 0; n < 128; n++) begin
      if (smp[n] != model(32 * n, 1'b1)) bad++;
      if (smp[n] > hi) hi = smp[n];
    end
    chk(bad == 0, "R6 clipped samples", bad, 0);
    chk(hi == 3645, "R6 clipped peak", hi, 3645);
  endtask

  task automatic t_midchange;
    int bad_old = 0, bad_new = 0;
    restart(20000, 1'b0);
    collect(0, 10);
    freq_hz = 15'd5000;
    collect(10, 138);
    for (int n = 0; n < 128; n++) if (smp[n] != model(32 * n, 1'b0)) bad_old++;
    for (int n = 128; n < 148; n++) if (smp[n] != model(8 * (n - 128), 1'b0)) bad_new++;
    chk(bad_old == 0, "R7 old stride kept until wrap", bad_old, 0);
    chk(bad_new == 0, "R7 new stride after wrap", bad_new, 0);
    chk(lens[100] == 128, "R7 length unchanged mid-cycle", lens[100], 128);
    chk(lens[140] == 512, "R7 length after wrap", lens[140], 512);
  endtask

  task automatic t_disable;
    int cnt = 0;
    restart(20000, 1'b0);
    collect(0, 5);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(dac_code == 12'd2048, "R8 disabled code", int'(dac_code), 2048);
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (sample_stb) cnt++;
      if (dac_code != 12'd2048) cnt += 1000;
    end
    chk(cnt == 0, "R8 no strobe and mid-scale while disabled", cnt, 0);
    enable = 1'b1;
    collect(0, 2);
    chk(smp[0] == model(0, 1'b0), "R8 restart at address 0", smp[0], model(0, 1'b0));
    chk(smp[1] == model(32, 1'b0), "R8 second sample after restart", smp[1], model(32, 1'b0));
  endtask

  initial begin
    t_reset();
    t_ranges();
    t_rate();
    t_short_cycle();
    t_clip();
    t_midchange();
    t_disable();
    t_full_table();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 195000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule